// File: doc/BRIEF.md
# NAND Flash Ready-Status Poller

This block waits for a NAND flash device to finish an internal operation. On a start pulse it latches a timeout and a poll spacing, lets a short settle interval pass, and sends the status opcode to a lower-level bus phase engine. After a fixed write-to-read turnaround it reads status bytes one at a time until the device reports ready or the time budget runs out.

Each request to the phase engine is held steady until the engine acknowledges it. A request is either a command byte or a single 8-bit data read. When ready is seen, the block sends the array-read opcode so that later data transfers return array contents rather than status. Only then does it report success. On a timeout it reports failure and leaves the device in status-output mode. Bus pin timing belongs to the phase engine, not to this block.

Top module: `nand_ready_poll`

## Requirements
- R1: After reset the block is idle: `busy`, `done` and `req_valid` are all 0.
- R2: A `start` seen while idle is followed by exactly SETTLE_CYC cycles with `busy`=1 and no request, before any request is made.
- R3: The first request is a command (`req_read`=0) with byte 0x70. Every request keeps `req_valid`, `req_read` and `req_byte` unchanged until the clock edge at which `req_ack` is 1.
- R4: After the status command is acknowledged there are exactly TURN_CYC cycles with no request, then the first status read.
- R5: A status read is a request with `req_read`=1, which is always a single 8-bit transfer. The device is ready when bit 6 of `rsp_data`, sampled with `req_ack`, is 1. At least one status read is always made.
- R6: After a not-ready status read that does not time out, there are exactly `cfg_gap`+1 cycles with no request before the next status read.
- R7: On a ready status, the block issues a command request with byte 0x00. After that command is acknowledged it raises `done` with `timed_out`=0.
- R8: Let E be the number of clock edges since the edge that acknowledged the status command, counted at the acknowledge of a not-ready status read. If E is at least `cfg_timeout`, the block raises `done` with `timed_out`=1 in the next cycle and issues no 0x00 command. A `cfg_timeout` of 0 therefore gives exactly one read.
- R9: `cfg_timeout` and `cfg_gap` are sampled only when a start is accepted. Changing them during an operation has no effect.
- R10: `start` has no effect while `busy` is 1, including in the `done` cycle.
- R11: `done` is a single-cycle pulse. In the cycle after it, `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one wait-for-ready operation |
| cfg_timeout | input | TMO_W | Time budget in clock cycles, counted from the status command acknowledge |
| cfg_gap | input | GAP_W | Idle cycles between status reads, minus one |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| timed_out | output | 1 | Valid with `done`: 1 means timeout, 0 means ready |
| req_valid | output | 1 | Request to the phase engine is pending |
| req_read | output | 1 | 1 = 8-bit data read, 0 = command byte |
| req_byte | output | 8 | Command opcode (meaningful when `req_read`=0) |
| req_ack | input | 1 | Phase engine accepts the request this cycle |
| rsp_data | input | 8 | Read data, valid when `req_ack` is 1 on a read |

## Verification
The assertions assume that the phase engine raises `req_ack` only while `req_valid` is 1. They also assume that `rsp_data` is meaningful only in an acknowledged read cycle. The stimulus keeps to this because the bench plays the phase engine itself: it raises the acknowledge for exactly one cycle, after a chosen latency, on a request it has already seen. Stray `start` pulses and configuration changes are made only while an operation is running. This exercises the rule that they are ignored without breaking the handshake assumption.

// File: rtl/nrp_pkg.sv
package nrp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_SCMD,
        ST_TURN,
        ST_POLL,
        ST_GAP,
        ST_RCMD,
        ST_FIN
    } nrp_state_e;

    typedef struct packed {
        logic       valid;
        logic       rd;
        logic [7:0] code;
    } nrp_req_t;

    localparam logic [7:0] OP_STATUS = 8'h70;
    localparam logic [7:0] OP_ARRAY  = 8'h00;
    localparam int         RDY_BIT   = 6;

    function automatic logic status_ready(input logic [7:0] s);
        return s[RDY_BIT];
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/nrp_delay.sv
module nrp_delay #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/nrp_elapsed.sv
module nrp_elapsed #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (inc && (cnt_q != '1)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count = cnt_q;
endmodule

// File: rtl/nand_ready_poll.sv
module nand_ready_poll
    import nrp_pkg::*;
#(
    parameter int TMO_W      = 16,
    parameter int GAP_W      = 8,
    parameter int SETTLE_CYC = 4,
    parameter int TURN_CYC   = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [TMO_W-1:0] cfg_timeout,
    input  logic [GAP_W-1:0] cfg_gap,
    output logic             busy,
    output logic             done,
    output logic             timed_out,
    output logic             req_valid,
    output logic             req_read,
    output logic [7:0]       req_byte,
    input  logic             req_ack,
    input  logic [7:0]       rsp_data
);
    localparam int SW = $clog2(SETTLE_CYC + 1);
    localparam int TW = $clog2(TURN_CYC + 1);
    localparam int DW = imax(GAP_W, imax(SW, TW));

    nrp_state_e       st_q, st_d;
    logic [TMO_W-1:0] tmo_q;
    logic [GAP_W-1:0] gap_q;
    logic             tflag_q;

    logic             dly_load, dly_zero;
    logic [DW-1:0]    dly_val;
    logic             el_clr, el_inc;
    logic [TMO_W-1:0] el_cnt;
    logic             rdy_seen, tmo_hit;
    nrp_req_t         req;

    nrp_delay #(.W(DW)) i_delay (
        .clk(clk), .rst(rst), .load(dly_load), .load_val(dly_val), .zero(dly_zero)
    );

    nrp_elapsed #(.W(TMO_W)) i_elapsed (
        .clk(clk), .rst(rst), .clr(el_clr), .inc(el_inc), .count(el_cnt)
    );

    assign rdy_seen = status_ready(rsp_data);
    assign tmo_hit  = (el_cnt >= tmo_q);

    always_comb begin
        st_d     = st_q;
        dly_load = 1'b0;
        dly_val  = '0;
        el_clr   = 1'b0;
        el_inc   = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (start) begin
                    st_d     = ST_SETTLE;
                    dly_load = 1'b1;
                    dly_val  = DW'(SETTLE_CYC - 1);
                end
            end
            ST_SETTLE: begin
                if (dly_zero) st_d = ST_SCMD;
            end
            ST_SCMD: begin
                if (req_ack) begin
                    st_d     = ST_TURN;
                    dly_load = 1'b1;
                    dly_val  = DW'(TURN_CYC - 1);
                    el_clr   = 1'b1;
                end
            end
            ST_TURN: begin
                el_inc = 1'b1;
                if (dly_zero) st_d = ST_POLL;
            end
            ST_POLL: begin
                el_inc = 1'b1;
                if (req_ack) begin
                    if (rdy_seen) begin
                        st_d = ST_RCMD;
                    end else if (tmo_hit) begin
                        st_d = ST_FIN;
                    end else begin
                        st_d     = ST_GAP;
                        dly_load = 1'b1;
                        dly_val  = DW'(gap_q);
                    end
                end
            end
            ST_GAP: begin
                el_inc = 1'b1;
                if (dly_zero) st_d = ST_POLL;
            end
            ST_RCMD: begin
                if (req_ack) st_d = ST_FIN;
            end
            ST_FIN:  st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            tmo_q   <= '0;
            gap_q   <= '0;
            tflag_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_IDLE && start) begin
                tmo_q   <= cfg_timeout;
                gap_q   <= cfg_gap;
                tflag_q <= 1'b0;
            end else if (st_q == ST_POLL && req_ack && !rdy_seen && tmo_hit) begin
                tflag_q <= 1'b1;
            end
        end
    end

    always_comb begin
        req.valid = (st_q == ST_SCMD) || (st_q == ST_POLL) || (st_q == ST_RCMD);
        req.rd    = (st_q == ST_POLL);
        req.code  = (st_q == ST_SCMD) ? OP_STATUS : OP_ARRAY;
    end

    assign req_valid = req.valid;
    assign req_read  = req.rd;
    assign req_byte  = req.code;
    assign busy      = (st_q != ST_IDLE);
    assign done      = (st_q == ST_FIN);
    assign timed_out = tflag_q;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ack) |=> (req_valid && $stable(req_read) && $stable(req_byte))) // R3
        else $error("request changed before acknowledge");

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy)) // R11
        else $error("done not a single pulse");

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> ($stable(tmo_q) && $stable(gap_q))) // R9
        else $error("configuration changed during operation");

    AST_TMO_FROM_POLL: assert property (@(posedge clk) disable iff (rst)
        (done && timed_out) |-> ($past(st_q) == ST_POLL && $past(el_cnt >= tmo_q))) // R8
        else $error("timeout reported without expired budget");

    AST_OK_AFTER_RCMD: assert property (@(posedge clk) disable iff (rst)
        (done && !timed_out) |-> ($past(st_q) == ST_RCMD)) // R7
        else $error("success reported without array command");

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy) // R10
        else $error("operation aborted while busy");
endmodule

// File: tb/test_nand_ready_poll.sv
module test_nand_ready_poll;
    localparam int TMO_W      = 16;
    localparam int GAP_W      = 8;
    localparam int SETTLE_CYC = 4;
    localparam int TURN_CYC   = 3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [TMO_W-1:0] cfg_timeout = '0;
    logic [GAP_W-1:0] cfg_gap = '0;
    logic             busy, done, timed_out, req_valid, req_read;
    logic [7:0]       req_byte;
    logic             req_ack = 1'b0;
    logic [7:0]       rsp_data = 8'h00;

    int compared = 0;
    int mismatched = 0;
    int e = 0;

    always #5 clk = ~clk;

    nand_ready_poll #(
        .TMO_W(TMO_W), .GAP_W(GAP_W), .SETTLE_CYC(SETTLE_CYC), .TURN_CYC(TURN_CYC)
    ) i_nand_ready_poll (
        .clk(clk), .rst(rst), .start(start), .cfg_timeout(cfg_timeout), .cfg_gap(cfg_gap),
        .busy(busy), .done(done), .timed_out(timed_out), .req_valid(req_valid),
        .req_read(req_read), .req_byte(req_byte), .req_ack(req_ack), .rsp_data(rsp_data)
    );

    task automatic tick();
        @(negedge clk);
        e++;
    endtask

    task automatic chk(string tag, bit ev, bit erd, int ebyte, bit ed, bit et, bit ebusy);
        bit bad;
        compared++;
        bad = (req_valid !== ev) || (done !== ed) || (busy !== ebusy);
        if (ev && (req_read !== erd)) bad = 1;
        if (ev && !erd && ebyte >= 0 && req_byte !== 8'(ebyte)) bad = 1;
        if (ed && timed_out !== et) bad = 1;
        if (bad) begin
            mismatched++;
            $display("FAIL %s: valid=%b rd=%b byte=%h done=%b tmo=%b busy=%b / expected valid=%b rd=%b byte=%0h done=%b tmo=%b busy=%b",
                     tag, req_valid, req_read, req_byte, done, timed_out, busy,
                     ev, erd, ebyte, ed, et, ebusy);
        end
    endtask

    // bench acts as phase engine: acknowledge after lat cycles
    task automatic hs(string tag, bit rd, int ebyte, int lat, logic [7:0] dat, output int e_ack);
        e_ack = 0;
        for (int k = 0; k <= lat; k++) begin
            chk(tag, 1'b1, rd, ebyte, 1'b0, 1'b0, 1'b1);
            if (k == lat) begin
                req_ack  = 1'b1;
                rsp_data = dat;
                e_ack    = e;
            end
            tick();
            req_ack  = 1'b0;
            rsp_data = 8'h00;
        end
    endtask

    task automatic run_op(int tmo, int gap, int lat, logic [7:0] st[$], bit disturb);
        int ea;
        bit finished;
        logic [7:0] s;
        int rcount;
        start = 1'b1;
        cfg_timeout = TMO_W'(tmo);
        cfg_gap = GAP_W'(gap);
        tick();
        start = 1'b0;
        for (int i = 0; i < SETTLE_CYC; i++) begin
            if (disturb && i == 1) begin
                start = 1'b1;            // R10 stray start
                cfg_timeout = '0;        // R9 late change
                cfg_gap = 8'd40;
            end else begin
                start = 1'b0;
            end
            chk("R2 settle", 1'b0, 1'b0, -1, 1'b0, 1'b0, 1'b1);
            tick();
        end
        start = 1'b0;
        hs("R3 status cmd", 1'b0, 8'h70, lat, 8'h00, ea);
        e = 0;
        for (int i = 0; i < TURN_CYC; i++) begin
            chk("R4 turnaround", 1'b0, 1'b0, -1, 1'b0, 1'b0, 1'b1);
            tick();
        end
        finished = 0;
        rcount = 0;
        while (!finished) begin
            s = (st.size() > 0) ? st.pop_front() : 8'h00;
            rcount++;
            hs("R5 status read", 1'b1, -1, lat, s, ea);
            if (s[6]) begin
                hs("R7 array cmd", 1'b0, 8'h00, lat, 8'h00, ea);
                chk("R7 done ok", 1'b0, 1'b0, -1, 1'b1, 1'b0, 1'b1);
                finished = 1;
            end else if (ea >= tmo) begin
                chk("R8 done timeout", 1'b0, 1'b0, -1, 1'b1, 1'b1, 1'b1);
                finished = 1;
            end else begin
                for (int g = 0; g <= gap; g++) begin
                    chk("R6 gap", 1'b0, 1'b0, -1, 1'b0, 1'b0, 1'b1);
                    tick();
                end
            end
        end
        if (disturb) start = 1'b1;       // R10 start in done cycle
        tick();
        start = 1'b0;
        chk("R11 idle after done", 1'b0, 1'b0, -1, 1'b0, 1'b0, 1'b0);
        tick();
        chk("R10 still idle", 1'b0, 1'b0, -1, 1'b0, 1'b0, 1'b0);
        tick();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: run did not end / expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic [7:0] q[$];
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            chk("R1 reset idle", 1'b0, 1'b0, -1, 1'b0, 1'b0, 1'b0);
            tick();
        end
        // ready on third read, bit 7 alone must not count
        q = '{8'h00, 8'h80, 8'h40};
        run_op(100, 2, 0, q, 1'b0);
        // ready on first read, slow acknowledge
        q = '{8'hFF};
        run_op(50, 0, 2, q, 1'b0);
        // timeout: every bit but bit 6 set
        q = '{8'hBF, 8'hBF, 8'hBF, 8'hBF, 8'hBF, 8'hBF, 8'hBF, 8'hBF};
        run_op(10, 3, 1, q, 1'b0);
        // zero budget: exactly one read then timeout (R8)
        q = '{8'h3F};
        run_op(0, 5, 0, q, 1'b0);
        // stray start and late config changes are ignored (R9, R10)
        q = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        run_op(12, 1, 0, q, 1'b1);
        q = '{8'h01, 8'h41};
        run_op(200, 4, 1, q, 1'b1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule